// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the seven status flags of an asynchronous serial port and drives the port's interrupt request. A transmitter and a receiver that live outside the block signal what happens to them through single-cycle event pulses. These events are: data register emptied, transmitter gone quiet, character received, receive line idle, overrun, noise and framing error. Each pulse sets the matching flag. The flags are presented as one 8-bit status word.

Software clears a flag in two steps. First it reads the status word while the flag is set, and that read arms the flag. Then it accesses the shared data register. A data write clears the armed transmit flags, and a data read clears the armed receive flags. A flag that sets after the status read is not armed, so it survives the access. The idle flag sets again only after the line has shown activity since the idle flag last set. The idle flag is also held off while the receiver is in wake-up mode.

All pins are plain control and status pins. There is no data stream, so no valid/ready back-pressure applies. The status word and the interrupt request are combinational views of registered state, so each one follows an event one clock edge after the event is seen.

Top module: `uart_flag_ctl`

## Requirements
- R1: The status word carries, from bit 7 down to bit 1: transmit-empty, transmit-done, receive-full, idle, overrun, noise, framing. Bit 0 always reads 0. Input vectors `set_evt` and `irq_en` use index i for status bit i+1.
- R2: After reset the status word reads 8'hC0.
- R3: Transmit-empty and transmit-done set on their events. They clear only when a `stat_rd` that saw them set is followed by a `data_wr`. A `data_wr` without that earlier read leaves them set.
- R4: Receive-full, overrun, noise and framing set on their events. They clear when a `stat_rd` that saw them set is followed by a `data_rd`.
- R5: A `data_wr` leaves the receive-side flags (bits 5..1) unchanged. A `data_rd` leaves the transmit-side flags (bits 7..6) unchanged.
- R6: A flag that sets after the last `stat_rd` is not cleared by the following data access.
- R7: The idle flag (status bit 4, `set_evt[3]`) sets on an idle event only if a `line_busy` pulse has arrived since reset or since the idle flag last set. It clears like the other receive flags.
- R8: While `wake_mode` is 1, idle events do not set the idle flag. The pending line activity is kept for later.
- R9: When a set event and a clear for the same flag fall in one cycle, the flag stays set.
- R10: `irq` is 1 exactly when some status bit 7..1 is set and its enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 7 | Flag set pulses; index i sets status bit i+1 |
| line_busy | input | 1 | Pulse: receive line showed activity |
| wake_mode | input | 1 | Receiver wake-up mode; blocks the idle flag |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| irq_en | input | 7 | Interrupt enables; index i covers status bit i+1 |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The clear path is tried in four forms. A data access with no earlier status read must clear nothing. A status read followed by the wrong kind of data access shows that the transmit and receive groups are separated. A flag set between the read and the access shows that arming is done per flag. A set event in the same cycle as the clearing access shows which one wins. The idle flag is driven with idle pulses with and without line activity and with wake-up mode on. This tells the re-arm rule apart from the wake-up hold-off.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int NUM_FLAGS = 7;
  localparam int STAT_W    = NUM_FLAGS + 1;
  // flag index i maps to status bit i+1
  localparam int IDX_TXE   = 6;
  localparam int IDX_TXC   = 5;
  localparam int IDX_RXF   = 4;
  localparam int IDX_IDLE  = 3;
  localparam int IDX_OVR   = 2;
  localparam int IDX_NOISE = 1;
  localparam int IDX_FRAME = 0;
  localparam int NUM_TX    = 2; // top flags cleared by a data write
  localparam logic [NUM_FLAGS-1:0] RST_FLAGS = 7'b110_0000;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      if (set_i)                flag_o <= 1'b1;
      else if (clr_i && armed_q) flag_o <= 1'b0;
      if (arm_i)                armed_q <= flag_o;
      else if (clr_i)           armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_idle_qual.sv
module uart_idle_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_evt_i,
  input  logic line_busy_i,
  input  logic wake_i,
  output logic idle_set_o
);
  logic seen_busy_q;

  assign idle_set_o = idle_evt_i && seen_busy_q && !wake_i;

  always_ff @(posedge clk) begin
    if (!rst_n)           seen_busy_q <= 1'b0;
    else if (line_busy_i) seen_busy_q <= 1'b1;
    else if (idle_set_o)  seen_busy_q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
  parameter int N = 7
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  assign irq_o = |(flags_i & en_i);
endmodule

// File: rtl/uart_flag_ctl.sv
module uart_flag_ctl
  import uart_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_evt,
  input  logic                 line_busy,
  input  logic                 wake_mode,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  input  logic                 data_wr,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [STAT_W-1:0]    status,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] set_q;
  logic                 idle_set;

  uart_idle_qual u_idle (
    .clk(clk), .rst_n(rst_n),
    .idle_evt_i(set_evt[IDX_IDLE]), .line_busy_i(line_busy),
    .wake_i(wake_mode), .idle_set_o(idle_set)
  );

  always_comb begin
    set_q           = set_evt;
    set_q[IDX_IDLE] = idle_set;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam bit IS_TX = (i >= NUM_FLAGS - NUM_TX);
    uart_flag_cell #(.RST_VAL(RST_FLAGS[i])) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_q[i]), .arm_i(stat_rd),
      .clr_i(IS_TX ? data_wr : data_rd),
      .flag_o(flags[i])
    );
  end

  assign status = {flags, 1'b0};

  uart_irq_merge #(.N(NUM_FLAGS)) u_irq (
    .flags_i(flags), .en_i(irq_en), .irq_o(irq)
  );
endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk
  import uart_flag_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_FLAGS-1:0] set_evt,
  input logic                 line_busy,
  input logic                 wake_mode,
  input logic                 stat_rd,
  input logic                 data_rd,
  input logic                 data_wr,
  input logic [NUM_FLAGS-1:0] irq_en,
  input logic [STAT_W-1:0]    status,
  input logic                 irq
);
  a_r1_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == 1'b0);
  a_r3_tx_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(data_wr));
  a_r4_rx_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(data_rd));
  a_r5_write_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !data_rd) |=> $stable(status[5:1]) || $past(|set_evt));
  a_r8_wake_blocks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !$past(wake_mode));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[IDX_RXF] |=> status[5]);
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status[7:1] & irq_en));
endmodule

bind uart_flag_ctl uart_flag_chk u_chk (.*);

// File: tb/tb_uart_flag_ctl.sv
module tb_uart_flag_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] set_evt = '0;
  logic       line_busy = 1'b0, wake_mode = 1'b0;
  logic       stat_rd = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
  logic [6:0] irq_en = '0;
  logic [7:0] status;
  logic       irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  uart_flag_ctl dut (.*);

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk); set_evt = ev;
    @(negedge clk); set_evt = '0;
  endtask
  task automatic srd();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask
  task automatic drd();
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
  endtask
  task automatic dwr();
    @(negedge clk); data_wr = 1; @(negedge clk); data_wr = 0;
  endtask
  task automatic busy();
    @(negedge clk); line_busy = 1; @(negedge clk); line_busy = 0;
  endtask

  task automatic t_reset();
    chk("R2 reset", status, 8'hC0);
    chk("R1 bit0", {7'd0, status[0]}, 8'h00);
    chk("R10 no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_tx();
    dwr();
    chk("R3 write without read", status, 8'hC0);
    srd(); dwr();
    chk("R3 read then write", status, 8'h00);
    pulse(7'b100_0000);
    chk("R3 tx empty set", status, 8'h80);
    pulse(7'b010_0000);
    chk("R3 tx done set", status, 8'hC0);
    srd(); dwr();
  endtask

  task automatic t_rx();
    pulse(7'b001_0000);
    chk("R4 rx full set", status, 8'h20);
    srd(); dwr();
    chk("R5 write keeps rx", status, 8'h20);
    srd(); drd();
    chk("R4 rx full cleared", status, 8'h00);
    pulse(7'b000_0111);
    chk("R1 ovr/noise/frame bits", status, 8'h0E);
    pulse(7'b100_0000);
    srd(); drd();
    chk("R5 read keeps tx, R4 clears err", status, 8'h80);
    srd(); dwr();
  endtask

  task automatic t_arm();
    pulse(7'b000_0100);
    srd();
    pulse(7'b000_0010);
    drd();
    chk("R6 late flag survives", status, 8'h04);
    srd(); drd();
    chk("R6 later cleared", status, 8'h00);
  endtask

  task automatic t_idle();
    pulse(7'b000_1000);
    chk("R7 idle without activity", status, 8'h00);
    busy(); pulse(7'b000_1000);
    chk("R7 idle after activity", status, 8'h10);
    srd(); drd();
    pulse(7'b000_1000);
    chk("R7 no reset without activity", status, 8'h00);
    busy();
    wake_mode = 1;
    pulse(7'b000_1000);
    chk("R8 wake blocks idle", status, 8'h00);
    wake_mode = 0;
    pulse(7'b000_1000);
    chk("R8 activity kept", status, 8'h10);
    srd(); drd();
  endtask

  task automatic t_setwins();
    pulse(7'b001_0000);
    srd();
    @(negedge clk); data_rd = 1; set_evt = 7'b001_0000;
    @(negedge clk); data_rd = 0; set_evt = '0;
    chk("R9 set wins", status, 8'h20);
  endtask

  task automatic t_irq();
    irq_en = 7'b001_0000;
    @(negedge clk);
    chk("R10 irq on", {7'd0, irq}, 8'h01);
    irq_en = 7'b100_0000;
    @(negedge clk);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    irq_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_arm();
    t_idle();
    t_setwins();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule